// File: doc/BRIEF.md
# Address-Filtering 9-bit UART Receiver

This block receives asynchronous serial frames that carry nine data bits, as used on a shared multi-drop line where many nodes listen to one sender. The ninth bit marks a frame as an address (1) or as payload (0). While the address-filter input is high, only frames with the ninth bit set are kept, so a node that is not addressed never sees the payload on the line. Once a node sees its own address, its controller clears the filter input and every frame that follows is kept.

Kept frames enter a two-entry queue. A non-empty queue raises the receive flag. Each entry carries a framing-error bit that is set when its stop bit was sampled low. A frame that arrives while the queue is full is lost and sets a sticky overrun flag. An internal rate generator makes the 16x oversampling tick, with a high-speed setting that drops a fixed divide-by-four prescale. A double-buffered transmitter that uses the same tick and the same frame format supports full duplex.

Top module: `mdrop_uart_top`

## Requirements
- R1: After reset, `rx_valid` and `rx_overrun` are 0, `txd` is 1 and `tx_ready` is 1.
- R2: With `addr_filt` low, every received frame is stored. `rx_data[0]` is the first data bit after the start bit and `rx_data[8]` is the ninth. `rx_valid` is 1 whenever the queue holds at least one entry.
- R3: With `addr_filt` high, a frame whose ninth bit is 1 is stored and raises `rx_valid`.
- R4: With `addr_filt` high, a frame whose ninth bit is 0 is discarded. `rx_valid` stays 0, the queue is unchanged and `rx_overrun` is not set.
- R5: The queue holds two frames and returns them in arrival order. Each `rx_pop` pulse removes the head entry.
- R6: A stored-class frame that arrives with two entries queued and no pop in the same cycle is dropped. It sets `rx_overrun`, which stays 1 until an `ovr_clr` pulse.
- R7: When a frame completes in the same cycle as an `rx_pop` on a full queue, the frame is accepted and `rx_overrun` stays 0.
- R8: `rx_ferr` is 1 for an entry whose stop bit was sampled low and 0 otherwise. Such a frame is still stored.
- R9: A start bit is accepted only when the majority of the samples at oversample positions 7, 8 and 9 of the bit is low. A low pulse shorter than seven ticks produces no frame.
- R10: A `tx_wr` while `tx_ready` is 1 queues one 9-bit word. `txd` then sends a low start bit, the nine bits LSB first and a high stop bit, each 16 ticks long. `tx_ready` is 0 while the holding stage is occupied, so one word can wait while another is being sent.
- R11: The tick period is `baud_div+1` clocks with `high_speed` at 1 and `4*(baud_div+1)` clocks with `high_speed` at 0. One bit lasts 16 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_div | input | 16 | Tick divider, period minus one |
| high_speed | input | 1 | 1: no prescale; 0: extra divide by four |
| addr_filt | input | 1 | Keep only frames whose ninth bit is 1 |
| rxd | input | 1 | Serial receive line, idle high |
| rx_pop | input | 1 | Remove the head entry of the queue |
| ovr_clr | input | 1 | Clear the sticky overrun flag |
| rx_valid | output | 1 | Receive flag: queue not empty |
| rx_data | output | 9 | Head entry data, bit 8 is the ninth bit |
| rx_ferr | output | 1 | Head entry framing error |
| rx_overrun | output | 1 | Sticky overrun flag |
| tx_data | input | 9 | Word to transmit |
| tx_wr | input | 1 | Write `tx_data` into the holding stage |
| tx_ready | output | 1 | Holding stage free |
| txd | output | 1 | Serial transmit line, idle high |

## Verification
A frame that completes and an `rx_pop` from the host can fall in the same cycle while the queue holds two entries. The correct result is that the head leaves and the new frame takes its place with no overrun. The bench provokes this by filling the queue and then sending a third frame. It raises `rx_pop` for exactly the cycle in which that frame is written: the line latency, two synchroniser stages plus the stop sample at position 9 plus one output register, puts this 172 clocks after the start-bit edge at one tick per clock. It judges the result by reading `rx_overrun` at 0 and then popping the two entries, which must be the second and third frames. A second collision, a completed frame on a full queue with no pop, is judged by the sticky flag and by the absence of the dropped frame.

// File: rtl/mdrop_pkg.sv
// Shared constants and types for the 9-bit multi-drop UART.
// Assumes 16x oversampling and a sample window in the middle of each bit.
package mdrop_pkg;
    localparam int DATA_W   = 9;               // data bits per frame
    localparam int OSR      = 16;              // ticks per bit
    localparam int POS_W    = $clog2(OSR);
    localparam int SMP0     = OSR / 2 - 1;     // first of the three votes
    localparam int TX_BITS  = DATA_W + 2;      // start + data + stop

    typedef struct packed {
        logic              ferr;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    localparam int ENTRY_W = $bits(rx_entry_t);
endpackage

// File: rtl/mdrop_baud_gen.sv
// Oversampling tick generator. Emits a one-clock tick every (div+1)
// clocks in high-speed mode, or every 4*(div+1) clocks otherwise.
// Assumes div is held stable while traffic is running.
module mdrop_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             high_speed,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 2;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // Reload value for the selected speed range.
    always_comb begin
        limit = high_speed ? {2'b00, div} : {div, 2'b11};
    end

    assign tick = (cnt == '0);

    // Down-counter that reloads on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= limit;
        else
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/mdrop_rx_frame.sv
// Receive deserializer. Synchronises the line, validates the start bit
// by a three-sample majority vote, shifts in nine bits LSB first and
// checks the stop bit. Emits a one-clock frame pulse with data and a
// framing-error bit. Returns to idle at the stop-bit vote so that a
// following start edge is not missed.
module mdrop_rx_frame
    import mdrop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    output logic              frm_valid,
    output logic [DATA_W-1:0] frm_data,
    output logic              frm_ferr
);
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

    localparam int BIT_W = $clog2(DATA_W + 1);
    localparam logic [POS_W-1:0] P_A   = POS_W'(SMP0);
    localparam logic [POS_W-1:0] P_B   = POS_W'(SMP0 + 1);
    localparam logic [POS_W-1:0] P_C   = POS_W'(SMP0 + 2);
    localparam logic [POS_W-1:0] P_END = POS_W'(OSR - 1);
    localparam logic [BIT_W-1:0] LAST  = BIT_W'(DATA_W - 1);

    rx_state_t         state;
    logic [1:0]        sync_q;
    logic              line;
    logic [POS_W-1:0]  pos;
    logic [BIT_W-1:0]  bitn;
    logic [2:0]        votes;
    logic [DATA_W-1:0] shreg;
    logic              vote_bit;
    logic              stop_bit;

    assign line = sync_q[1];

    // Two-stage synchroniser for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= 2'b11;
        else
            sync_q <= {sync_q[0], rxd};
    end

    // Majority of the three stored votes, and of the stop-bit votes
    // including the sample taken in the current cycle.
    always_comb begin
        vote_bit = (votes[0] & votes[1]) | (votes[0] & votes[2]) | (votes[1] & votes[2]);
        stop_bit = (votes[0] & votes[1]) | (votes[0] & line) | (votes[1] & line);
    end

    // Bit-timing state machine and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            pos       <= '0;
            bitn      <= '0;
            votes     <= 3'b111;
            shreg     <= '0;
            frm_valid <= 1'b0;
            frm_data  <= '0;
            frm_ferr  <= 1'b0;
        end else begin
            frm_valid <= 1'b0;
            if (tick) begin
                if (state == RX_IDLE) begin
                    if (!line) begin
                        state <= RX_START;
                        pos   <= POS_W'(1);
                    end
                end else begin
                    pos <= pos + 1'b1;
                    if (pos == P_A) votes[0] <= line;
                    if (pos == P_B) votes[1] <= line;
                    if (pos == P_C) votes[2] <= line;
                    case (state)
                        RX_START: begin
                            if (pos == P_END) begin
                                bitn  <= '0;
                                state <= vote_bit ? RX_IDLE : RX_DATA;
                            end
                        end
                        RX_DATA: begin
                            if (pos == P_END) begin
                                shreg <= {vote_bit, shreg[DATA_W-1:1]};
                                if (bitn == LAST)
                                    state <= RX_STOP;
                                else
                                    bitn <= bitn + 1'b1;
                            end
                        end
                        RX_STOP: begin
                            if (pos == P_C) begin
                                frm_valid <= 1'b1;
                                frm_data  <= shreg;
                                frm_ferr  <= ~stop_bit;
                                state     <= RX_IDLE;
                            end
                        end
                        default: state <= RX_IDLE;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/mdrop_rx_fifo.sv
// Small receive queue. A write is accepted when the queue has room or
// a read happens in the same cycle; a read on an empty queue is
// ignored. Assumes DEPTH is small (register storage).
module mdrop_rx_fifo #(
    parameter int WIDTH = 10,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rd,
    output logic [WIDTH-1:0] head,
    output logic             not_empty,
    output logic             full,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             wr_ok, rd_ok;

    assign not_empty = (level != '0);
    assign full      = (level == LVL_MAX);
    assign rd_ok     = rd && not_empty;
    assign wr_ok     = wr && (!full || rd);
    assign head      = mem[rp];

    // Storage write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_ok) begin
            mem[wp] <= wdata;
        end
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (wr_ok) wp <= (wp == PTR_MAX) ? '0 : wp + 1'b1;
            if (rd_ok) rp <= (rp == PTR_MAX) ? '0 : rp + 1'b1;
            case ({wr_ok, rd_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/mdrop_tx.sv
// Double-buffered transmitter: a holding register feeds a shift
// register that sends start, nine data bits LSB first and stop, each
// OSR ticks long. A write while the holding register is full is ignored.
module mdrop_tx
    import mdrop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    output logic              ready,
    output logic              txd,
    output logic              busy
);
    localparam int NB_W = $clog2(TX_BITS);
    localparam logic [POS_W-1:0] P_END = POS_W'(OSR - 1);
    localparam logic [NB_W-1:0]  NB_LAST = NB_W'(TX_BITS - 1);

    logic              hold_v;
    logic [DATA_W-1:0] hold_d;
    logic [TX_BITS-1:0] shreg;
    logic [POS_W-1:0]  pos;
    logic [NB_W-1:0]   nbits;

    assign ready = ~hold_v;
    assign txd   = busy ? shreg[0] : 1'b1;

    // Holding stage, shifter load and bit timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v <= 1'b0;
            hold_d <= '0;
            shreg  <= '1;
            pos    <= '0;
            nbits  <= '0;
            busy   <= 1'b0;
        end else begin
            if (wr && !hold_v) begin
                hold_v <= 1'b1;
                hold_d <= wdata;
            end
            if (tick) begin
                if (!busy) begin
                    if (hold_v) begin
                        shreg  <= {1'b1, hold_d, 1'b0};
                        busy   <= 1'b1;
                        pos    <= '0;
                        nbits  <= '0;
                        hold_v <= 1'b0;
                    end
                end else begin
                    pos <= pos + 1'b1;
                    if (pos == P_END) begin
                        shreg <= {1'b1, shreg[TX_BITS-1:1]};
                        if (nbits == NB_LAST)
                            busy <= 1'b0;
                        else
                            nbits <= nbits + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mdrop_uart_top.sv
// 9-bit multi-drop UART. Receiver with optional address filtering on
// the ninth bit, a receive queue with sticky overrun, and (when TX_EN)
// a double-buffered transmitter sharing the tick generator.
module mdrop_uart_top
    import mdrop_pkg::*;
#(
    parameter int DIV_W    = 16,
    parameter int Q_DEPTH  = 2,
    parameter bit TX_EN    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              high_speed,
    input  logic              addr_filt,
    input  logic              rxd,
    input  logic              rx_pop,
    input  logic              ovr_clr,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ferr,
    output logic              rx_overrun,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_wr,
    output logic              tx_ready,
    output logic              txd
);
    localparam int LVL_W = $clog2(Q_DEPTH + 1);

    logic              tick;
    logic              frm_valid;
    logic [DATA_W-1:0] frm_data;
    logic              frm_ferr;
    logic              keep;
    logic              q_full;
    logic [LVL_W-1:0]  q_level;
    logic              tx_busy;
    rx_entry_t         q_in, q_head;

    mdrop_baud_gen #(.DIV_W(DIV_W)) baud_i (
        .clk(clk), .rst_n(rst_n), .div(baud_div),
        .high_speed(high_speed), .tick(tick)
    );

    mdrop_rx_frame rx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .frm_valid(frm_valid), .frm_data(frm_data), .frm_ferr(frm_ferr)
    );

    // Address filter: with the filter on, only ninth-bit-set frames pass.
    always_comb begin
        keep      = frm_valid && (!addr_filt || frm_data[DATA_W-1]);
        q_in.data = frm_data;
        q_in.ferr = frm_ferr;
    end

    mdrop_rx_fifo #(.WIDTH(ENTRY_W), .DEPTH(Q_DEPTH)) q_i (
        .clk(clk), .rst_n(rst_n), .wr(keep), .wdata(q_in), .rd(rx_pop),
        .head(q_head), .not_empty(rx_valid), .full(q_full), .level(q_level)
    );

    assign rx_data = q_head.data;
    assign rx_ferr = q_head.ferr;

    // Sticky overrun: set when a kept frame finds no room.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_overrun <= 1'b0;
        else if (ovr_clr)
            rx_overrun <= 1'b0;
        else if (keep && q_full && !rx_pop)
            rx_overrun <= 1'b1;
    end

    generate
        if (TX_EN) begin : g_tx
            mdrop_tx tx_i (
                .clk(clk), .rst_n(rst_n), .tick(tick), .wdata(tx_data),
                .wr(tx_wr), .ready(tx_ready), .txd(txd), .busy(tx_busy)
            );
        end else begin : g_no_tx
            logic unused_tx;
            assign unused_tx = ^{tx_data, tx_wr};
            assign tx_ready  = 1'b0;
            assign txd       = 1'b1;
            assign tx_busy   = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/mdrop_uart_chk.sv
// Property checker for mdrop_uart_top, attached by bind below.
module mdrop_uart_chk #(
    parameter int LVL_W = 2,
    parameter int DEPTH = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             addr_filt,
    input logic             frm_valid,
    input logic [8:0]       frm_data,
    input logic             keep,
    input logic             rx_pop,
    input logic             ovr_clr,
    input logic             rx_valid,
    input logic             rx_overrun,
    input logic [LVL_W-1:0] q_level,
    input logic             tx_busy,
    input logic             txd
);
    // R4: a filtered payload frame never reaches the queue
    a_r4_drop_payload: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && addr_filt && !frm_data[8] |-> !keep);

    // R3: a filtered address frame is kept
    a_r3_keep_address: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid && addr_filt && frm_data[8] |-> keep);

    // R5: occupancy never exceeds the depth
    a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q_level <= LVL_W'(DEPTH));

    // R2: receive flag follows occupancy
    a_r2_flag_level: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid == (q_level != '0));

    // R6: overrun is sticky until cleared
    a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun && !ovr_clr |=> rx_overrun);

    // R6: a kept frame on a full queue without pop raises overrun
    a_r6_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        keep && q_level == LVL_W'(DEPTH) && !rx_pop && !ovr_clr |=> rx_overrun);

    // R7: push with pop on a full queue keeps it full
    a_r7_push_pop_full: assert property (@(posedge clk) disable iff (!rst_n)
        keep && rx_pop && q_level == LVL_W'(DEPTH) |=> q_level == LVL_W'(DEPTH));

    // R10: line idles high while nothing is being sent
    a_r10_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);
endmodule

bind mdrop_uart_top mdrop_uart_chk #(.LVL_W(LVL_W), .DEPTH(Q_DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .addr_filt(addr_filt), .frm_valid(frm_valid),
    .frm_data(frm_data), .keep(keep), .rx_pop(rx_pop), .ovr_clr(ovr_clr),
    .rx_valid(rx_valid), .rx_overrun(rx_overrun), .q_level(q_level),
    .tx_busy(tx_busy), .txd(txd)
);

// File: tb/mdrop_uart_tb_top.sv
module mdrop_uart_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] baud_div = 16'd0;
    logic        high_speed = 1'b1;
    logic        addr_filt = 1'b0;
    logic        drv_rxd = 1'b1;
    logic        loop = 1'b0;
    logic        rx_pop = 1'b0;
    logic        ovr_clr = 1'b0;
    logic        rx_valid, rx_ferr, rx_overrun, tx_ready, txd;
    logic [8:0]  rx_data;
    logic [8:0]  tx_data = 9'd0;
    logic        tx_wr = 1'b0;
    logic        rxd_w;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    assign rxd_w = loop ? txd : drv_rxd;

    always #4 clk = ~clk;

    mdrop_uart_top dut_i (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .high_speed(high_speed),
        .addr_filt(addr_filt), .rxd(rxd_w), .rx_pop(rx_pop), .ovr_clr(ovr_clr),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ferr(rx_ferr),
        .rx_overrun(rx_overrun), .tx_data(tx_data), .tx_wr(tx_wr),
        .tx_ready(tx_ready), .txd(txd)
    );

    // {addr_filt, stop level, expect stored, data[8:0]}
    localparam logic [11:0] VEC [8] = '{
        {1'b0, 1'b1, 1'b1, 9'h0A5},
        {1'b0, 1'b1, 1'b1, 9'h15A},
        {1'b1, 1'b1, 1'b1, 9'h1C3},
        {1'b1, 1'b1, 1'b0, 9'h03C},
        {1'b1, 1'b1, 1'b1, 9'h1FF},
        {1'b0, 1'b0, 1'b1, 9'h155},
        {1'b1, 1'b1, 1'b0, 9'h000},
        {1'b0, 1'b1, 1'b1, 9'h001}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one frame, bitlen clocks per bit; rx_pop is high for the
    // clock that follows clock index pop_at (negative: never).
    task automatic send(input logic [8:0] d, input logic stop, input int bitlen, input int pop_at);
        logic [10:0] fr;
        fr = {stop, d, 1'b0};
        for (int b = 0; b < 11; b++) begin
            for (int s = 0; s < bitlen; s++) begin
                if (s == 0) drv_rxd = fr[b];
                rx_pop = ((b * bitlen + s) == pop_at);
                @(negedge clk);
            end
        end
        rx_pop  = 1'b0;
        drv_rxd = 1'b1;
        repeat (24) @(negedge clk);
    endtask

    task automatic pop();
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_head(input string req, input logic [8:0] d, input logic fe);
        check(req, rx_valid, 1'b1);
        check(req, rx_data, d);
        check(req, rx_ferr, fe);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1 rx_valid", rx_valid, 1'b0);
        check("R1 overrun", rx_overrun, 1'b0);
        check("R1 txd", txd, 1'b1);
        check("R1 tx_ready", tx_ready, 1'b1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2 R3 R4 R8: vector walk
        foreach (VEC[i]) begin
            addr_filt = VEC[i][11];
            send(VEC[i][8:0], VEC[i][10], 16, -1);
            check($sformatf("R4 vec%0d stored", i), rx_valid, VEC[i][9]);
            if (VEC[i][9]) begin
                expect_head($sformatf("R2 R8 vec%0d", i), VEC[i][8:0], ~VEC[i][10]);
                pop();
                check($sformatf("R5 vec%0d empty", i), rx_valid, 1'b0);
            end
            check($sformatf("R4 vec%0d no overrun", i), rx_overrun, 1'b0);
        end
        addr_filt = 1'b0;

        // R5: two entries in order
        send(9'h011, 1'b1, 16, -1);
        send(9'h122, 1'b1, 16, -1);
        expect_head("R5 first", 9'h011, 1'b0);
        pop();
        expect_head("R5 second", 9'h122, 1'b0);
        pop();
        check("R5 drained", rx_valid, 1'b0);

        // R6: third frame on a full queue is dropped, flag sticky
        send(9'h033, 1'b1, 16, -1);
        send(9'h144, 1'b1, 16, -1);
        send(9'h055, 1'b1, 16, -1);
        check("R6 overrun set", rx_overrun, 1'b1);
        expect_head("R6 head", 9'h033, 1'b0);
        pop();
        expect_head("R6 next", 9'h144, 1'b0);
        pop();
        check("R6 dropped frame absent", rx_valid, 1'b0);
        check("R6 still sticky", rx_overrun, 1'b1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        @(negedge clk);
        check("R6 cleared", rx_overrun, 1'b0);

        // R7: pop in the exact write cycle of a frame on a full queue
        send(9'h066, 1'b1, 16, -1);
        send(9'h177, 1'b1, 16, -1);
        send(9'h088, 1'b1, 16, 172);
        check("R7 no overrun", rx_overrun, 1'b0);
        expect_head("R7 head", 9'h177, 1'b0);
        pop();
        expect_head("R7 new frame", 9'h088, 1'b0);
        pop();
        check("R7 drained", rx_valid, 1'b0);

        // R9: short low glitch is rejected
        drv_rxd = 1'b0;
        repeat (6) @(negedge clk);
        drv_rxd = 1'b1;
        repeat (300) @(negedge clk);
        check("R9 glitch no frame", rx_valid, 1'b0);
        send(9'h0F0, 1'b1, 16, -1);
        expect_head("R9 frame after glitch", 9'h0F0, 1'b0);
        pop();

        // R11: low-speed range, 64 clocks per bit
        high_speed = 1'b0;
        repeat (8) @(negedge clk);
        send(9'h1A6, 1'b1, 64, -1);
        expect_head("R11 low speed", 9'h1A6, 1'b0);
        pop();
        high_speed = 1'b1;
        repeat (8) @(negedge clk);

        // R10: double-buffered transmit through loop-back
        loop = 1'b1;
        repeat (4) @(negedge clk);
        tx_data = 9'h1B4;
        tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 holding freed", tx_ready, 1'b1);
        tx_data = 9'h04B;
        tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        check("R10 holding full", tx_ready, 1'b0);
        for (int t = 0; t < 400 && !rx_valid; t++) @(negedge clk);
        expect_head("R10 first word", 9'h1B4, 1'b0);
        pop();
        for (int t = 0; t < 400 && !rx_valid; t++) @(negedge clk);
        expect_head("R10 second word", 9'h04B, 1'b0);
        pop();
        repeat (40) @(negedge clk);
        check("R10 line idle", txd, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule